// File: doc/BRIEF.md
# Circular Interrupt Event Queue

This block collects per-channel event reports and turns each into a 16-bit entry in a circular table of 128 slots held in flops inside the block. The host drains the table: it reads entries through a read port and releases each one through an entry-clear port. The hardware and the host coordinate through two handshake bits in every slot. A valid bit marks an entry that the host has not yet consumed. A wrap bit marks the last slot of the ring.

Channels offer one event at a time on a valid/ready stream: a 6-bit channel number and eight cause bits. Each channel has a 16-bit cause mask, laid out like an entry, that selects which causes may be posted. An event with no cause left after masking is absorbed without touching the table. Every post sets a global interrupt event bit. If the slot at the write pointer is still valid, the event is dropped and an overflow event bit is set. Two further event bits record global transmit underrun and global receive overrun pulses. The host clears event bits by writing ones. A 16-bit mask register gates the event bits onto the interrupt line.

Back-pressure rule: an event on the stream is taken on a rising clock edge where both `ev_valid` and `ev_ready` are high. `ev_ready` drops only in a cycle where the host's entry-clear port targets the slot at the write pointer. The source holds the event and its fields stable until it is taken.

Top module: `irq_event_queue`

## Requirements
- R1: A posted entry has bit 15 = 1 (valid), bit 14 = the slot's own wrap bit, bit 13 = NID cause, bit 12 = IDL cause, bits 11:6 = channel number, and bits 5:0 = MRF, UN, RXF, BSY, TXB, RXB. On the input, `ev_cause[7]` is NID, `ev_cause[6]` is IDL and `ev_cause[5:0]` maps to entry bits 5:0.
- R2: Each channel's 16-bit mask uses the entry layout (bits 13, 12 and 5:0; 1 = let the cause pass) and is ANDed with the causes. All channel masks reset to 0. An event with no cause left after masking writes no slot, does not move the pointer and sets no event bit.
- R3: After reset every slot reads 0, except slot 127, which reads 0x4000 (wrap only). After a post into a slot with its wrap bit set, the write pointer returns to slot 0. Otherwise it advances by one.
- R4: When the slot at the write pointer is still valid, the event is dropped, event bit 3 (overflow) is set, event bit 2 is not set, the slot keeps its contents, and the pointer stays on that slot.
- R5: An entry clear to a slot zeroes every bit of that slot except the wrap bit.
- R6: Every successful post sets event bit 2 (global interrupt).
- R7: A high `glb_tx_underrun` sets event bit 1. A high `glb_rx_overrun` sets event bit 0.
- R8: An event-register write clears each bit written as 1. Bits written as 0 are untouched. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: `irq` is high exactly when any bit of the zero-extended event register ANDed with the 16-bit mask register is set. The mask resets to 0.
- R10: `ev_ready` is low exactly while `clr_en` is high and `clr_addr` equals the write pointer.
- R11: `rd_data` shows the slot addressed by `rd_addr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event offered on the stream |
| ev_ready | output | 1 | Event can be taken this cycle |
| ev_chan | input | 6 | Channel number of the event |
| ev_cause | input | 8 | Cause bits: NID, IDL, MRF, UN, RXF, BSY, TXB, RXB |
| chmask_we | input | 1 | Write a channel cause mask |
| chmask_chan | input | 6 | Channel whose mask is written |
| chmask_data | input | 16 | Mask value in entry layout |
| rd_addr | input | 7 | Slot to read |
| rd_data | output | 16 | Slot contents, one cycle after the address |
| clr_en | input | 1 | Release a slot |
| clr_addr | input | 7 | Slot to release |
| glb_tx_underrun | input | 1 | Global transmit underrun pulse |
| glb_rx_overrun | input | 1 | Global receive overrun pulse |
| evt_we | input | 1 | Write-one-to-clear strobe for the event register |
| evt_wdata | input | 4 | Bits to clear |
| evt_q | output | 4 | Event register: overflow, interrupt, tx underrun, rx overrun |
| mask_we | input | 1 | Write the interrupt mask register |
| mask_wdata | input | 16 | New interrupt mask value |
| irq | output | 1 | Masked interrupt to the host |

## Verification
The assertions assume that the host's clear port and a post never touch the same slot in one cycle. The ready rule guarantees this for any source that honours `ev_ready`. They also assume that `ev_chan` names a channel inside the configured count. The stimulus honours the handshake, uses only channel numbers below 64, and keeps every entry clear off slots that the check in progress still relies on. The bench raises the clear request that collides with the write pointer only briefly, and drops it before any clock edge. That lets it probe `ev_ready` without disturbing the table.

// File: rtl/ieq_pkg.sv
package ieq_pkg;
  localparam int CHAN_W    = 6;
  localparam int ENTRY_W   = 16;
  localparam int FIELD_W   = 14;
  localparam int CAUSE_W   = 8;
  localparam int VALID_BIT = 15;
  localparam int WRAP_BIT  = 14;
  localparam int EVT_W     = 4;
  localparam int EVT_OVF   = 3;
  localparam int EVT_INT   = 2;
  localparam int EVT_TXU   = 1;
  localparam int EVT_RXO   = 0;

  // place the eight input causes at their entry bit positions
  function automatic logic [ENTRY_W-1:0] spread_causes(input logic [CAUSE_W-1:0] c);
    return {2'b00, c[7:6], 6'b000000, c[5:0]};
  endfunction
endpackage

// File: rtl/ieq_chan_filter.sv
module ieq_chan_filter
  import ieq_pkg::*;
#(
  parameter int NUM_CHANS = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CHAN_W-1:0]    cfg_chan,
  input  logic [ENTRY_W-1:0]   cfg_data,
  input  logic [CHAN_W-1:0]    ev_chan,
  input  logic [CAUSE_W-1:0]   ev_cause,
  output logic [FIELD_W-1:0]   post_fields,
  output logic                 post_any
);
  logic [ENTRY_W-1:0] mask_tab [NUM_CHANS];
  logic [ENTRY_W-1:0] sel_mask;
  logic [ENTRY_W-1:0] kept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CHANS; i++) mask_tab[i] <= '0;
    end else if (cfg_we) begin
      mask_tab[cfg_chan] <= cfg_data;
    end
  end

  always_comb begin
    sel_mask    = mask_tab[ev_chan];
    kept        = spread_causes(ev_cause) & sel_mask;
    post_any    = |kept;
    post_fields = kept[FIELD_W-1:0] | {2'b00, ev_chan, 6'b000000};
  end
endmodule

// File: rtl/ieq_ring.sv
module ieq_ring
  import ieq_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [FIELD_W-1:0]   req_fields,
  output logic                 req_ready,
  output logic                 posted,
  output logic                 overflow,
  input  logic                 clr_en,
  input  logic [PTR_W-1:0]     clr_addr,
  input  logic [PTR_W-1:0]     rd_addr,
  output logic [ENTRY_W-1:0]   rd_data
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]   wr_ptr;
  logic               slot_busy;
  logic               slot_wrap;
  logic               take;

  always_comb begin
    slot_busy = mem[wr_ptr][VALID_BIT];
    slot_wrap = mem[wr_ptr][WRAP_BIT];
    req_ready = !(clr_en && (clr_addr == wr_ptr));
    take      = req_valid && req_ready;
    posted    = take && !slot_busy;
    overflow  = take && slot_busy;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        mem[i] <= (i == DEPTH - 1) ? ENTRY_W'(1 << WRAP_BIT) : '0;
      wr_ptr <= '0;
    end else begin
      if (clr_en)
        mem[clr_addr] <= {1'b0, mem[clr_addr][WRAP_BIT], {FIELD_W{1'b0}}};
      if (posted) begin
        mem[wr_ptr] <= {1'b1, slot_wrap, req_fields};
        wr_ptr      <= slot_wrap ? '0 : wr_ptr + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= mem[rd_addr];
  end

  assert_overflow_holds_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mem[wr_ptr][VALID_BIT]) |=> (wr_ptr == $past(wr_ptr)));

  assert_wrap_returns_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (posted && mem[wr_ptr][WRAP_BIT]) |=> (wr_ptr == '0));

  assert_post_marks_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !mem[wr_ptr][VALID_BIT]) |=> mem[$past(wr_ptr)][VALID_BIT]);

  assert_clear_drops_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !mem[$past(clr_addr)][VALID_BIT]);
endmodule

// File: rtl/ieq_events.sv
module ieq_events
  import ieq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_W-1:0]   set_vec,
  input  logic               wr_en,
  input  logic [EVT_W-1:0]   wr_data,
  input  logic               mask_we,
  input  logic [15:0]        mask_data,
  output logic [EVT_W-1:0]   evt_q,
  output logic               irq
);
  logic [15:0] mask_q;

  for (genvar k = 0; k < EVT_W; k++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) evt_q[k] <= 1'b0;
      else        evt_q[k] <= set_vec[k] | (evt_q[k] & ~(wr_en & wr_data[k]));
    end

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[k] |=> evt_q[k]);

    assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[k] && !set_vec[k]) |=> !evt_q[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= mask_data;
  end

  assign irq = |({{(16-EVT_W){1'b0}}, evt_q} & mask_q);
endmodule

// File: rtl/irq_event_queue.sv
module irq_event_queue
  import ieq_pkg::*;
#(
  parameter int NUM_CHANS = 64,
  parameter int DEPTH     = 128
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ev_valid,
  output logic                       ev_ready,
  input  logic [5:0]                 ev_chan,
  input  logic [7:0]                 ev_cause,
  input  logic                       chmask_we,
  input  logic [5:0]                 chmask_chan,
  input  logic [15:0]                chmask_data,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr,
  output logic [15:0]                rd_data,
  input  logic                       clr_en,
  input  logic [$clog2(DEPTH)-1:0]   clr_addr,
  input  logic                       glb_tx_underrun,
  input  logic                       glb_rx_overrun,
  input  logic                       evt_we,
  input  logic [3:0]                 evt_wdata,
  output logic [3:0]                 evt_q,
  input  logic                       mask_we,
  input  logic [15:0]                mask_wdata,
  output logic                       irq
);
  logic [FIELD_W-1:0] fields;
  logic               any_cause;
  logic               posted;
  logic               overflow;
  logic [EVT_W-1:0]   set_vec;

  ieq_chan_filter #(.NUM_CHANS(NUM_CHANS)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (chmask_we),
    .cfg_chan    (chmask_chan),
    .cfg_data    (chmask_data),
    .ev_chan     (ev_chan),
    .ev_cause    (ev_cause),
    .post_fields (fields),
    .post_any    (any_cause)
  );

  ieq_ring #(.DEPTH(DEPTH)) u_ring (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (ev_valid && any_cause),
    .req_fields (fields),
    .req_ready  (ev_ready),
    .posted     (posted),
    .overflow   (overflow),
    .clr_en     (clr_en),
    .clr_addr   (clr_addr),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[EVT_OVF] = overflow;
    set_vec[EVT_INT] = posted;
    set_vec[EVT_TXU] = glb_tx_underrun;
    set_vec[EVT_RXO] = glb_rx_overrun;
  end

  ieq_events u_events (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_vec   (set_vec),
    .wr_en     (evt_we),
    .wr_data   (evt_wdata),
    .mask_we   (mask_we),
    .mask_data (mask_wdata),
    .evt_q     (evt_q),
    .irq       (irq)
  );
endmodule

// File: tb/irq_event_queue_tb_top.sv
`timescale 1ns/1ps
module irq_event_queue_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [5:0]  ev_chan = '0;
  logic [7:0]  ev_cause = '0;
  logic        chmask_we = 1'b0;
  logic [5:0]  chmask_chan = '0;
  logic [15:0] chmask_data = '0;
  logic [6:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        clr_en = 1'b0;
  logic [6:0]  clr_addr = '0;
  logic        glb_tx_underrun = 1'b0;
  logic        glb_rx_overrun = 1'b0;
  logic        evt_we = 1'b0;
  logic [3:0]  evt_wdata = '0;
  logic [3:0]  evt_q;
  logic        mask_we = 1'b0;
  logic [15:0] mask_wdata = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  logic [15:0] bench_mask [64];
  logic [15:0] got;

  always #4 clk = ~clk;

  irq_event_queue dut_i (.*);

  // {channel, causes}
  localparam logic [13:0] VEC [8] = '{
    {6'd3,  8'h02}, {6'd63, 8'hFF}, {6'd0,  8'h80}, {6'd9,  8'hFF},
    {6'd17, 8'h40}, {6'd42, 8'h21}, {6'd1,  8'h3C}, {6'd30, 8'hC3}
  };

  function automatic logic [15:0] expect_entry(input logic [5:0] ch, input logic [7:0] c,
                                               input logic [15:0] m, input logic w);
    logic [15:0] e;
    e = 16'h8000;
    e[14] = w;
    e[13] = c[7] & m[13];
    e[12] = c[6] & m[12];
    e[11:6] = ch;
    e[5:0] = c[5:0] & m[5:0];
    return e;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic post(input logic [5:0] ch, input logic [7:0] c);
    @(negedge clk);
    ev_valid = 1'b1; ev_chan = ch; ev_cause = c;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic evt_clear(input logic [3:0] v);
    @(negedge clk);
    evt_we = 1'b1; evt_wdata = v;
    @(negedge clk);
    evt_we = 1'b0;
  endtask

  task automatic set_irq_mask(input logic [15:0] v);
    @(negedge clk);
    mask_we = 1'b1; mask_wdata = v;
    @(negedge clk);
    mask_we = 1'b0;
  endtask

  task automatic clear_slot(input logic [6:0] a);
    @(negedge clk);
    clr_en = 1'b1; clr_addr = a;
    @(negedge clk);
    clr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    chk("R9 reset evt", {12'b0, evt_q}, 16'h0);
    chk("R9 reset irq", {15'b0, irq}, 16'h0);
    chk("R10 reset ready", {15'b0, ev_ready}, 16'h1);
    rd(7'd127, got); chk("R3 reset wrap slot (R11 read)", got, 16'h4000);
    rd(7'd0, got);   chk("R3 reset slot0", got, 16'h0000);

    // channel masks
    for (int c = 0; c < 64; c++) begin
      bench_mask[c] = (c == 9) ? 16'h0005 : (c == 20) ? 16'h0000 : 16'hFFFF;
      @(negedge clk);
      chmask_we = 1'b1; chmask_chan = 6'(c); chmask_data = bench_mask[c];
    end
    @(negedge clk);
    chmask_we = 1'b0;

    // vector walk: slots 0..7
    for (int i = 0; i < 8; i++) begin
      post(VEC[i][13:8], VEC[i][7:0]);
      rd(7'(i), got);
      chk("R1 R2 entry layout", got,
          expect_entry(VEC[i][13:8], VEC[i][7:0], bench_mask[VEC[i][13:8]], 1'b0));
    end
    chk("R6 post sets interrupt bit", {12'b0, evt_q}, 16'h4);

    // fully masked channel: nothing posted
    evt_clear(4'hF);
    post(6'd20, 8'hFF);
    rd(7'd8, got); chk("R2 masked event leaves slot", got, 16'h0);
    chk("R2 masked event no event bit", {12'b0, evt_q}, 16'h0);

    // post into slot 8; interrupt mask behaviour
    post(6'd4, 8'h10);
    rd(7'd8, got); chk("R3 pointer held after masked event", got, expect_entry(6'd4, 8'h10, 16'hFFFF, 1'b0));
    chk("R6 evt after post", {12'b0, evt_q}, 16'h4);
    chk("R9 irq with mask 0", {15'b0, irq}, 16'h0);
    set_irq_mask(16'h0004);
    chk("R9 irq with mask bit2", {15'b0, irq}, 16'h1);
    set_irq_mask(16'h0008);
    chk("R9 irq with other bit", {15'b0, irq}, 16'h0);
    set_irq_mask(16'hFFF0);
    chk("R9 irq upper mask bits", {15'b0, irq}, 16'h0);
    set_irq_mask(16'h0000);

    // global event inputs and write-one-clear
    @(negedge clk); glb_tx_underrun = 1'b1;
    @(negedge clk); glb_tx_underrun = 1'b0;
    chk("R7 tx underrun", {12'b0, evt_q}, 16'h6);
    @(negedge clk); glb_rx_overrun = 1'b1;
    @(negedge clk); glb_rx_overrun = 1'b0;
    chk("R7 rx overrun", {12'b0, evt_q}, 16'h7);
    evt_clear(4'h2);
    chk("R8 clear one bit", {12'b0, evt_q}, 16'h5);
    @(negedge clk);
    glb_rx_overrun = 1'b1; evt_we = 1'b1; evt_wdata = 4'h1;
    @(negedge clk);
    glb_rx_overrun = 1'b0; evt_we = 1'b0;
    chk("R8 set wins over clear", {12'b0, evt_q}, 16'h5);
    evt_clear(4'hF);
    chk("R8 clear all", {12'b0, evt_q}, 16'h0);

    // fill slots 9..127
    for (int i = 9; i < 128; i++) post(6'd3, 8'h01);
    rd(7'd126, got); chk("R3 slot before wrap", got, expect_entry(6'd3, 8'h01, 16'hFFFF, 1'b0));
    rd(7'd127, got); chk("R1 R3 wrap slot keeps wrap", got, expect_entry(6'd3, 8'h01, 16'hFFFF, 1'b1));

    // overflow at slot 0
    evt_clear(4'hF);
    post(6'd5, 8'h02);
    chk("R4 overflow bit only", {12'b0, evt_q}, 16'h8);
    rd(7'd0, got); chk("R4 slot untouched", got, expect_entry(VEC[0][13:8], VEC[0][7:0], 16'hFFFF, 1'b0));

    clear_slot(7'd0);
    rd(7'd0, got); chk("R5 clear slot0", got, 16'h0000);
    post(6'd5, 8'h02);
    rd(7'd0, got); chk("R4 R3 retry lands in slot0", got, expect_entry(6'd5, 8'h02, 16'hFFFF, 1'b0));
    rd(7'd1, got); chk("R3 slot1 untouched", got, expect_entry(VEC[1][13:8], VEC[1][7:0], 16'hFFFF, 1'b0));

    clear_slot(7'd127);
    rd(7'd127, got); chk("R5 clear keeps wrap", got, 16'h4000);

    // read latency
    @(negedge clk);
    rd_addr = 7'd0;
    #1 chk("R11 old data before edge", rd_data, 16'h4000);
    @(negedge clk);
    chk("R11 new data after edge", rd_data, expect_entry(6'd5, 8'h02, 16'hFFFF, 1'b0));

    // back-pressure probe: write pointer is at slot 1
    @(negedge clk);
    clr_en = 1'b1; clr_addr = 7'd1;
    #1 chk("R10 ready low on collision", {15'b0, ev_ready}, 16'h0);
    clr_addr = 7'd2;
    #1 chk("R10 ready high elsewhere", {15'b0, ev_ready}, 16'h1);
    clr_en = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule